// File: doc/BRIEF.md
# Endian-Selectable Bus Width Converter

This block moves data between a 36-bit long word and 18-bit or 9-bit sub-words. It can go in either direction. On the split side, one long word taken at the input leaves as two or four narrower transfers. On the pack side, two or four narrow transfers are gathered into one long word. When both sides have the same width, each transfer passes straight through.

Both sides use a valid/ready handshake. The input width, the output width and the sub-word order are sampled from three configuration inputs only while reset is held low. After reset they are frozen, so a single design can sit behind buses of different shapes.

In big-endian order the most significant part of a long word travels first, and in little-endian order the least significant part travels first. The same rule applies when splitting and when packing. A narrow sub-word always uses the low bits of the 36-bit data buses.

Top module: `buswidth_conv`

## Requirements
- R1: The width selects and the order select are captured on every clock edge at which `rst_n` is low. Changing them while `rst_n` is high has no effect on behaviour.
- R2: Width select codes are 0 for 36 bits, 1 for 18 bits and 2 for 9 bits; code 3 is treated as 36 bits. A narrow sub-word occupies bits [w-1:0] of the bus. Input bits above the selected input width are ignored, and output bits above the selected output width read as zero while `out_valid` is high.
- R3: The supported pairs are 36 to 18, 36 to 9, 18 to 36, 9 to 36 and any equal pair. A pair in which both sides are narrow and the widths differ behaves as pass-through at the input width.
- R4: When splitting with `cfg_le` low, the most significant sub-word is sent first and the following ones in falling significance. With `cfg_le` high, the least significant sub-word is sent first and the following ones in rising significance.
- R5: When packing with `cfg_le` low, the first sub-word accepted lands in the most significant slot. With `cfg_le` high it lands in the least significant slot, and later sub-words fill the slots in the same direction.
- R6: When splitting, each accepted long word produces exactly ratio output transfers, where ratio is 2 or 4. `in_ready` is high only when no sub-word is pending, or when the last pending sub-word is being taken in that cycle.
- R7: When packing, `out_valid` rises only after ratio sub-words have been accepted. A partly gathered word is never presented. While a full word waits, `in_ready` follows `out_ready`.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay unchanged. The sub-word position advances only on an accepted handshake.
- R9: With equal widths, each accepted input transfer yields one output transfer carrying the same low bits.
- R10: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous master reset, active low; configuration is captured while low |
| cfg_in_w | input | 2 | Input width select (0: 36, 1: 18, 2: 9, 3: 36) |
| cfg_out_w | input | 2 | Output width select, same coding |
| cfg_le | input | 1 | Order select: low for most significant first, high for least significant first |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Input transfer can be taken |
| in_data | input | 36 | Input data, narrow sub-words in the low bits |
| out_valid | output | 1 | Output transfer offered |
| out_ready | input | 1 | Downstream takes the output transfer |
| out_data | output | 36 | Output data, narrow sub-words in the low bits, unused bits zero |

## Verification
The bench targets the order of sub-words in both directions under both order settings. A design with a reversed slot index would deliver a split word's parts in the wrong order, or pack a word with its halves swapped. It also sends a sub-word count that is not a multiple of the ratio, so a packer that leaks a partly filled word would present an unexpected output. Random back-pressure catches a counter that advances on offers rather than accepted transfers, which would skip or repeat sub-words. Further cases change the configuration pins after reset and use the unsupported narrow pairs and code 3, exposing a design that keeps sampling its pins or decodes those pairs differently.

// File: rtl/buswidth_conv_pkg.sv
package buswidth_conv_pkg;

  localparam int unsigned CNT_W = 4;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    WSEL_FULL    = 2'd0,
    WSEL_HALF    = 2'd1,
    WSEL_QUARTER = 2'd2,
    WSEL_SPARE   = 2'd3
  } wsel_e;

  typedef enum logic {
    DIR_SPLIT = 1'b0,
    DIR_PACK  = 1'b1
  } dir_e;

  typedef struct packed {
    dir_e  dir;
    logic  little;
    cnt_t  in_lanes;
    cnt_t  out_lanes;
    cnt_t  ratio;
  } conv_cfg_t;

  // Number of base lanes covered by a width select code.
  function automatic cnt_t lanes_for(input logic [1:0] sel, input cnt_t all);
    case (wsel_e'(sel))
      WSEL_HALF:    return all >> 1;
      WSEL_QUARTER: return all >> 2;
      default:      return all;
    endcase
  endfunction

  // Resolve the pin settings into direction, lane counts and transfer ratio.
  function automatic conv_cfg_t decode_cfg(input logic [1:0] isel,
                                           input logic [1:0] osel,
                                           input logic       le_pin,
                                           input cnt_t       all);
    conv_cfg_t c;
    cnt_t      il;
    cnt_t      ol;
    il = lanes_for(isel, all);
    ol = lanes_for(osel, all);
    // two different narrow widths: fall back to pass-through at input width
    if (il != all && ol != all) ol = il;
    c.little    = le_pin;
    c.in_lanes  = il;
    c.out_lanes = ol;
    if (il < ol) begin
      c.dir   = DIR_PACK;
      c.ratio = ol / il;
    end else begin
      c.dir   = DIR_SPLIT;
      c.ratio = il / ol;
    end
    return c;
  endfunction

  // Slot of the long word that a given beat touches.
  function automatic cnt_t slot_of(input cnt_t beat, input cnt_t ratio, input logic little);
    return little ? beat : ratio - beat - cnt_t'(1);
  endfunction

endpackage

// File: rtl/buswidth_conv_cfg.sv
module buswidth_conv_cfg
  import buswidth_conv_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] in_sel,
  input  logic [1:0] out_sel,
  input  logic       le_sel,
  output conv_cfg_t  cfg
);

  conv_cfg_t cfg_q;

  // Captured on every edge while reset is low, frozen afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= decode_cfg(in_sel, out_sel, le_sel, cnt_t'(LANES));
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/buswidth_conv_beat.sv
module buswidth_conv_beat
  import buswidth_conv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  cnt_t limit,
  output cnt_t cnt,
  output logic last
);

  cnt_t cnt_q;

  assign last = (cnt_q == limit - cnt_t'(1));
  assign cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (adv) cnt_q <= last ? '0 : cnt_q + cnt_t'(1);
  end

endmodule

// File: rtl/buswidth_conv_lanes.sv
module buswidth_conv_lanes
  import buswidth_conv_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 4
) (
  input  logic [LANES*LANE_W-1:0]      in_bus,
  input  logic [LANES-1:0][LANE_W-1:0] hold,
  input  cnt_t                         wr_slot,
  input  cnt_t                         wr_width,
  input  cnt_t                         rd_slot,
  input  cnt_t                         rd_width,
  output logic [LANES-1:0]             wr_en,
  output logic [LANES-1:0][LANE_W-1:0] wr_lane,
  output logic [LANES*LANE_W-1:0]      out_bus
);

  localparam int unsigned IDX_W = $clog2(LANES);

  logic [LANES-1:0][LANE_W-1:0] in_lanes;
  logic [LANES-1:0][LANE_W-1:0] out_lanes;
  cnt_t wr_base;
  cnt_t rd_base;

  assign in_lanes = in_bus;
  assign wr_base  = wr_slot * wr_width;
  assign rd_base  = rd_slot * rd_width;

  for (genvar L = 0; L < LANES; L++) begin : g_lane
    cnt_t             here;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;

    assign here   = cnt_t'(L);
    assign wr_idx = IDX_W'(here - wr_base);
    assign rd_idx = IDX_W'(rd_base + here);

    // lane L of the long word belongs to the slot being written
    assign wr_en[L]     = (here >= wr_base) && (here < wr_base + wr_width);
    assign wr_lane[L]   = in_lanes[wr_idx];
    // output lane L shows the matching lane of the slot being read
    assign out_lanes[L] = (here < rd_width) ? hold[rd_idx] : '0;
  end

  assign out_bus = out_lanes;

endmodule

// File: rtl/buswidth_conv.sv
module buswidth_conv
  import buswidth_conv_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              cfg_in_w,
  input  logic [1:0]              cfg_out_w,
  input  logic                    cfg_le,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*LANE_W-1:0] in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*LANE_W-1:0] out_data
);

  conv_cfg_t cfg_q;
  cnt_t      beat_cnt;
  cnt_t      slot;
  cnt_t      wr_slot;
  cnt_t      rd_slot;
  logic      beat_last;
  logic      is_pack;
  logic      fire_in;
  logic      fire_out;
  logic      beat_adv;
  logic      full_q;

  logic [LANES-1:0][LANE_W-1:0] hold_q;
  logic [LANES-1:0][LANE_W-1:0] wr_lane;
  logic [LANES-1:0]             wr_en;

  buswidth_conv_cfg #(.LANES(LANES)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_sel  (cfg_in_w),
    .out_sel (cfg_out_w),
    .le_sel  (cfg_le),
    .cfg     (cfg_q)
  );

  assign is_pack  = (cfg_q.dir == DIR_PACK);
  assign fire_in  = in_valid && in_ready;
  assign fire_out = out_valid && out_ready;
  assign beat_adv = is_pack ? fire_in : fire_out;

  buswidth_conv_beat u_beat (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (beat_adv),
    .limit (cfg_q.ratio),
    .cnt   (beat_cnt),
    .last  (beat_last)
  );

  assign slot    = slot_of(beat_cnt, cfg_q.ratio, cfg_q.little);
  assign wr_slot = is_pack ? slot : '0;
  assign rd_slot = is_pack ? '0 : slot;

  buswidth_conv_lanes #(.LANE_W(LANE_W), .LANES(LANES)) u_lanes (
    .in_bus   (in_data),
    .hold     (hold_q),
    .wr_slot  (wr_slot),
    .wr_width (cfg_q.in_lanes),
    .rd_slot  (rd_slot),
    .rd_width (cfg_q.out_lanes),
    .wr_en    (wr_en),
    .wr_lane  (wr_lane),
    .out_bus  (out_data)
  );

  // Pack: a full word blocks only until it is taken.
  // Split: a new word waits for the last sub-word to leave.
  assign in_ready  = is_pack ? (!full_q || out_ready)
                             : (!full_q || (out_ready && beat_last));
  assign out_valid = full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else if (is_pack) begin
      if (fire_in && beat_last) full_q <= 1'b1;
      else if (fire_out)        full_q <= 1'b0;
    end else begin
      if (fire_in)                     full_q <= 1'b1;
      else if (fire_out && beat_last)  full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (fire_in && wr_en[l]) hold_q[l] <= wr_lane[l];
      end
    end
  end

endmodule

// File: rtl/buswidth_conv_chk.sv
module buswidth_conv_chk
  import buswidth_conv_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [LANES*LANE_W-1:0] out_data,
  input logic                    fire_in,
  input logic                    fire_out,
  input logic                    is_pack,
  input cnt_t                    ratio,
  input cnt_t                    out_lanes,
  input cnt_t                    beat_cnt,
  input logic [1:0]              cfg_in_w,
  input logic [1:0]              cfg_out_w,
  input logic                    cfg_le,
  input logic [2*CNT_W+1:0]      cfg_word
);

  cnt_t in_seen;
  cnt_t out_seen;
  logic had_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_seen  <= '0;
      out_seen <= '0;
      had_word <= 1'b0;
    end else begin
      if (fire_out)     in_seen <= fire_in ? cnt_t'(1) : '0;
      else if (fire_in) in_seen <= in_seen + cnt_t'(1);
      if (fire_in)       out_seen <= '0;
      else if (fire_out) out_seen <= out_seen + cnt_t'(1);
      if (fire_in) had_word <= 1'b1;
    end
  end

  // R1: settings frozen after reset (pins themselves may move)
  p_cfg_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(cfg_word) && $stable(ratio) && $stable(is_pack));

  // R2: bits above the output width read zero
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_data >> (out_lanes * LANE_W)) == '0));

  // R6: a split word is replaced only after all its sub-words left
  p_split_drained_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_in && !is_pack && had_word) |-> ((out_seen + cnt_t'(fire_out)) == ratio));

  // R7: a packed word leaves only after ratio sub-words arrived
  p_pack_complete_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_out && is_pack) |-> (in_seen == ratio));

  // R8: output held under back-pressure
  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8: beat position stays inside the ratio
  p_beat_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    beat_cnt < ratio);

  // R10: nothing pending means input can be taken
  p_idle_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  logic unused_pins;
  assign unused_pins = ^{cfg_in_w, cfg_out_w, cfg_le};

endmodule

bind buswidth_conv buswidth_conv_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .fire_in   (fire_in),
  .fire_out  (fire_out),
  .is_pack   (is_pack),
  .ratio     (cfg_q.ratio),
  .out_lanes (cfg_q.out_lanes),
  .beat_cnt  (beat_cnt),
  .cfg_in_w  (cfg_in_w),
  .cfg_out_w (cfg_out_w),
  .cfg_le    (cfg_le),
  .cfg_word  (cfg_q)
);

// File: tb/buswidth_conv_tb.sv
module buswidth_conv_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LW = 9;
  localparam int NL = 4;
  localparam int WW = LW * NL;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    cfg_in_w;
  logic [1:0]    cfg_out_w;
  logic          cfg_le;
  logic          in_valid;
  logic          in_ready;
  logic [WW-1:0] in_data;
  logic          out_valid;
  logic          out_ready;
  logic [WW-1:0] out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  buswidth_conv #(.LANE_W(LW), .LANES(NL)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_in_w  (cfg_in_w),
    .cfg_out_w (cfg_out_w),
    .cfg_le    (cfg_le),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  logic [WW-1:0] exp_q[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  bit    mon_on   = 0;
  bit    stall_en = 0;
  bit    pack_mode = 0;
  string cur_tag  = "R10";

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int width_bits(input logic [1:0] sel);
    case (sel)
      2'd1:    return 18;
      2'd2:    return 9;
      default: return 36;
    endcase
  endfunction

  function automatic logic [WW-1:0] low_mask(input int bits);
    if (bits >= WW) return '1;
    return (36'd1 << bits) - 36'd1;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // downstream readiness, changed just after each rising edge
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      out_ready = stall_en ? ($urandom % 3 != 0) : 1'b1;
    end
  end

  // scoreboard monitor: samples mid-cycle, values hold until next edge
  initial begin
    bit            prev_stall;
    logic [WW-1:0] prev_data;
    logic [WW-1:0] e;
    bit            exp_v;
    bit            exp_r;
    prev_stall = 0;
    prev_data  = '0;
    forever begin
      @(negedge clk);
      if (!mon_on) begin
        prev_stall = 0;
      end else begin
        exp_v = (exp_q.size() > 0);
        check(out_valid == exp_v, pack_mode ? "R7" : "R6", "out_valid",
              36'(out_valid), 36'(exp_v));
        if (pack_mode) exp_r = !exp_v || out_ready;
        else           exp_r = (exp_q.size() == 0) || (exp_q.size() == 1 && out_ready);
        check(in_ready == exp_r, pack_mode ? "R7" : "R6", "in_ready",
              36'(in_ready), 36'(exp_r));
        if (prev_stall)
          check(out_valid && out_data == prev_data, "R8", "held output",
                out_data, prev_data);
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(0, cur_tag, "unexpected output", out_data, '0);
          end else begin
            e = exp_q.pop_front();
            check(out_data == e, cur_tag, "output data", out_data, e);
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
      end
    end
  end

  task automatic run_case(input string tag, input logic [1:0] iw, input logic [1:0] ow,
                          input bit le, input int n_items, input bit stall, input bit flip);
    int            isw;
    int            osw;
    int            ratio;
    int            cnt;
    int            idx;
    int            t;
    bit            took;
    logic [WW-1:0] acc;
    logic [WW-1:0] d;
    isw = width_bits(iw);
    osw = width_bits(ow);
    if (isw != WW && osw != WW) osw = isw;   // R3 fallback
    pack_mode = (isw < osw);
    ratio = pack_mode ? osw / isw : isw / osw;
    cnt = 0;
    acc = '0;

    mon_on = 0;
    @(posedge clk);
    #1;
    exp_q.delete();
    stall_en  = stall;
    cur_tag   = tag;
    rst_n     = 1'b0;
    cfg_in_w  = iw;
    cfg_out_w = ow;
    cfg_le    = le;
    in_valid  = 1'b0;
    in_data   = '0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    if (flip) begin   // R1: late pin changes must be ignored
      cfg_in_w  = ~iw;
      cfg_out_w = ~ow;
      cfg_le    = ~le;
    end
    @(negedge clk);
    check(out_valid == 1'b0, "R10", "out_valid after reset", 36'(out_valid), '0);
    check(in_ready == 1'b1, "R10", "in_ready after reset", 36'(in_ready), 36'd1);
    mon_on = 1;
    @(posedge clk);
    #1;

    for (int i = 0; i < n_items; i++) begin
      d = {4'($urandom), $urandom};
      if ($urandom % 4 == 0) begin
        in_valid = 1'b0;
        @(posedge clk);
        #1;
      end
      in_valid = 1'b1;
      in_data  = d;
      do begin
        @(negedge clk);
        took = in_ready;
        @(posedge clk);
        #1;
      end while (!took);
      if (pack_mode) begin
        idx = le ? cnt : ratio - 1 - cnt;
        acc = acc | ((d & low_mask(isw)) << (idx * isw));
        cnt++;
        if (cnt == ratio) begin
          exp_q.push_back(acc);
          acc = '0;
          cnt = 0;
        end
      end else begin
        for (int k = 0; k < ratio; k++) begin
          idx = le ? k : ratio - 1 - k;
          exp_q.push_back((d >> (idx * osw)) & low_mask(osw));
        end
      end
    end
    in_valid = 1'b0;

    t = 0;
    while (exp_q.size() != 0 && t < 2000) begin
      @(posedge clk);
      t++;
    end
    repeat (8) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, tag, "all expected items delivered",
          36'(exp_q.size()), '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual still running, expected finished");
    finish_run();
  end

  initial begin
    rst_n     = 1'b0;
    cfg_in_w  = 2'd0;
    cfg_out_w = 2'd0;
    cfg_le    = 1'b0;
    in_valid  = 1'b0;
    in_data   = '0;

    // R4: split order
    run_case("R4", 2'd0, 2'd1, 1'b0, 20, 1'b1, 1'b0);
    run_case("R4", 2'd0, 2'd1, 1'b1, 20, 1'b0, 1'b0);
    // R6: four-way split
    run_case("R6", 2'd0, 2'd2, 1'b0, 16, 1'b1, 1'b0);
    run_case("R6", 2'd0, 2'd2, 1'b1, 16, 1'b0, 1'b0);
    // R5: pack order
    run_case("R5", 2'd1, 2'd0, 1'b0, 20, 1'b0, 1'b0);
    run_case("R5", 2'd1, 2'd0, 1'b1, 20, 1'b1, 1'b0);
    // R7: partial word left at the end must never appear
    run_case("R7", 2'd2, 2'd0, 1'b0, 13, 1'b1, 1'b0);
    run_case("R7", 2'd2, 2'd0, 1'b1, 22, 1'b0, 1'b0);
    // R9: equal widths
    run_case("R9", 2'd0, 2'd0, 1'b0, 16, 1'b1, 1'b0);
    run_case("R9", 2'd1, 2'd1, 1'b1, 16, 1'b0, 1'b0);
    run_case("R9", 2'd2, 2'd2, 1'b0, 16, 1'b1, 1'b0);
    // R3: unsupported narrow pairs
    run_case("R3", 2'd1, 2'd2, 1'b0, 16, 1'b1, 1'b0);
    run_case("R3", 2'd2, 2'd1, 1'b1, 16, 1'b0, 1'b0);
    // R2: spare code reads as full width
    run_case("R2", 2'd3, 2'd1, 1'b0, 16, 1'b1, 1'b0);
    run_case("R2", 2'd2, 2'd3, 1'b1, 16, 1'b0, 1'b0);
    // R1: pins flipped after reset
    run_case("R1", 2'd0, 2'd2, 1'b1, 16, 1'b1, 1'b1);
    run_case("R1", 2'd1, 2'd0, 1'b0, 16, 1'b0, 1'b1);

    mon_on = 0;
    finish_run();
  end

endmodule